// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a free-running 32-bit counter paired with a 32-bit compare register, of the kind a processor core keeps for operating-system time slicing. The counter advances by one on every cycle in which the tick-enable input is high. A prescaler outside the block therefore sets the timer rate. Software may overwrite the counter at any time, and counting then resumes from the written value. When a tick arrives while the counter equals the compare value, the block raises one line of an 8-bit interrupt vector. The line is chosen by a 3-bit select field.

The interrupt stays asserted until software writes the compare register. That write is the only acknowledge. A freeze input stops the counter. While it is set, no new interrupt is raised and a compare write does not lower an active one. An optional sticky pending flag is set together with the interrupt when the `REV2` parameter is 1. The bus decode of the surrounding register file is outside the block.

Top module: `cc_timer`

## Requirements
- R1: After reset, `count_rd` reads 1, the compare register holds 0, `tmr_pending` is 0 and `irq_vec` is all zeros.
- R2: On each clock edge where `tick_en` is 1, `count_wr` is 0 and `count_hold` is 0, the count increases by one. With `tick_en` at 0, the count keeps its value.
- R3: A clock edge with `compare_wr` at 1 loads `wr_data` into the compare register. If `count_hold` is 0 at that edge, `irq_vec` becomes all zeros and `tmr_pending` becomes 0 at the same edge, and this takes priority over a match at that edge.
- R4: A match is a clock edge where `tick_en` is 1, `count_hold` is 0, neither write strobe is 1, and the count equals the compare value. After a match edge, bit `line_sel` of `irq_vec` is 1.
- R5: A match edge sets `tmr_pending` only when `REV2` is 1. With `REV2` at 0, `tmr_pending` stays 0.
- R6: The interrupt and `tmr_pending` stay set as the count moves past the compare value. Only a compare write with `count_hold` at 0, or reset, clears them.
- R7: At most one bit of `irq_vec` is 1. Changing `line_sel` moves an active interrupt to the newly selected bit in the same cycle.
- R8: A `count_wr` edge loads `wr_data` into the count and never produces a match. If the written value equals the compare value, the interrupt rises only after the next tick edge.
- R9: While `count_hold` is 1, ticks leave the count unchanged and raise no interrupt.
- R10: A compare write while `count_hold` is 1 stores the new value but leaves an active interrupt and `tmr_pending` set.
- R11: The count wraps from 0xFFFFFFFF to 0x00000000, and a compare value of 0 matches after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance enable for this cycle |
| count_wr | input | 1 | Write strobe for the count register |
| compare_wr | input | 1 | Write strobe for the compare register (acknowledges interrupt) |
| wr_data | input | 32 | Write data shared by both strobes |
| count_hold | input | 1 | Freeze: stops counting and interrupt changes |
| line_sel | input | 3 | Selects which interrupt line carries the timer interrupt |
| count_rd | output | 32 | Current count value |
| tmr_pending | output | 1 | Sticky timer-pending flag (only with REV2) |
| irq_vec | output | 8 | Interrupt vector, at most one bit set |

## Verification
A count register that has been corrupted is visible on `count_rd` from the next edge. A missed or spurious match is harder to see, because the interrupt is sticky. It appears on `irq_vec` one edge after the tick concerned and then stays, so an early or late raise differs from the expected result in a single cycle only. The bench therefore compares every cycle against a model, and does not check only the end states. A stale interrupt-active bit is caught at the next compare write, which must clear it, or at the next `line_sel` change, which must move it.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W     = 32,
  parameter int LINES     = 8,
  parameter int SEL_W     = $clog2(LINES),
  parameter bit REV2      = 1'b1,
  parameter logic [CNT_W-1:0] CNT_INIT = 1,
  parameter logic [CNT_W-1:0] CMP_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             count_wr,
  input  logic             compare_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             count_hold,
  input  logic [SEL_W-1:0] line_sel,
  output logic [CNT_W-1:0] count_rd,
  output logic             tmr_pending,
  output logic [LINES-1:0] irq_vec
);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             irq_q, pend_q;
  logic             run, hit, ack;

  assign run = tick_en & ~count_hold;
  assign hit = run & ~count_wr & ~compare_wr & (cnt_q == cmp_q);
  assign ack = compare_wr & ~count_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (count_wr) begin
      cnt_q <= wr_data;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= CMP_INIT;
    end else if (compare_wr) begin
      cmp_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (ack) begin
      irq_q <= 1'b0;
    end else if (hit) begin
      irq_q <= 1'b1;
    end
  end

  generate
    if (REV2) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
        end else if (ack) begin
          pend_q <= 1'b0;
        end else if (hit) begin
          pend_q <= 1'b1;
        end
      end
    end else begin : g_nopend
      assign pend_q = 1'b0;
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      assign irq_vec[i] = irq_q & (line_sel == SEL_W'(i));
    end
  endgenerate

  assign count_rd    = cnt_q;
  assign tmr_pending = pend_q;

endmodule

module cc_timer_chk #(
  parameter int CNT_W = 32,
  parameter int LINES = 8,
  parameter int SEL_W = 3,
  parameter bit REV2  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             count_wr,
  input logic             compare_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic             count_hold,
  input logic [SEL_W-1:0] line_sel,
  input logic [CNT_W-1:0] count_rd,
  input logic [CNT_W-1:0] cmp_q,
  input logic             tmr_pending,
  input logic [LINES-1:0] irq_vec
);

  // R2
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !count_hold && !count_wr) |=> (count_rd == $past(count_rd) + 1'b1));

  // R3
  cmp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compare_wr && !count_hold) |=> (irq_vec == '0 && !tmr_pending));

  // R4
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !count_hold && !count_wr && !compare_wr && count_rd == cmp_q) |=> (irq_vec != '0));

  // R5
  rev_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REV2 == 1'b0) |-> !tmr_pending);

  // R7
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_vec));

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> (count_rd == $past(wr_data)));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hold && !count_wr) |=> $stable(count_rd));

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hold && irq_vec != '0) |=> (irq_vec != '0));

endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .LINES(LINES), .SEL_W(SEL_W), .REV2(REV2)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_wr(count_wr),
  .compare_wr(compare_wr), .wr_data(wr_data), .count_hold(count_hold),
  .line_sel(line_sel), .count_rd(count_rd), .cmp_q(cmp_q),
  .tmr_pending(tmr_pending), .irq_vec(irq_vec)
);

// File: tb/cc_timer_tb_top.sv
module cc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, count_wr = 1'b0, compare_wr = 1'b0, count_hold = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  line_sel = '0;
  logic [31:0] count_rd;
  logic        tmr_pending;
  logic [7:0]  irq_vec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] cnt;
    logic        pend;
    logic [7:0]  vec;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_cnt, m_cmp;
  logic        m_irq, m_pend;

  always #5 clk = ~clk;

  cc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_wr(count_wr),
    .compare_wr(compare_wr), .wr_data(wr_data), .count_hold(count_hold),
    .line_sel(line_sel), .count_rd(count_rd), .tmr_pending(tmr_pending),
    .irq_vec(irq_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic cw, input logic kw, input logic [31:0] d,
                      input logic hd, input logic [2:0] sel, input string tag);
    logic hit, ack;
    exp_t e;
    @(negedge clk);
    tick_en = tk; count_wr = cw; compare_wr = kw; wr_data = d; count_hold = hd; line_sel = sel;
    hit = tk && !hd && !cw && !kw && (m_cnt == m_cmp);
    ack = kw && !hd;
    if (cw) m_cnt = d; else if (tk && !hd) m_cnt = m_cnt + 1;
    if (kw) m_cmp = d;
    if (ack) begin m_irq = 0; m_pend = 0; end
    else if (hit) begin m_irq = 1; m_pend = 1; end
    e.cnt = m_cnt; e.pend = m_pend;
    e.vec = m_irq ? (8'd1 << sel) : 8'd0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " count"}, count_rd, e.cnt);
        check({e.tag, " pend"}, {31'd0, tmr_pending}, {31'd0, e.pend});
        check({e.tag, " vec"}, {24'd0, irq_vec}, {24'd0, e.vec});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    #3;
    check("R1 count", count_rd, 32'd1);
    check("R1 pend", {31'd0, tmr_pending}, 32'd0);
    check("R1 vec", {24'd0, irq_vec}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: compare resets to 0, so a count written to 0 matches on the next tick
    step(0, 1, 0, 32'd0, 0, 3'd2, "R1 load");
    step(1, 0, 0, 0, 0, 3'd2, "R1 match-zero");
    step(0, 0, 1, 32'd100, 0, 3'd2, "R3 ack");
    // R2: advance and idle
    step(0, 1, 0, 32'd5, 0, 3'd0, "R2 load");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 3'd0, "R2 tick");
    step(0, 0, 0, 0, 0, 3'd0, "R2 idle");
    // R4/R5/R6: count up to compare
    step(0, 0, 1, 32'd13, 0, 3'd7, "R3 cmp");
    step(0, 1, 0, 32'd10, 0, 3'd7, "R8 load");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 3'd7, "R4 approach");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 3'd7, "R6 sticky");
    // R7: move line
    step(1, 0, 0, 0, 0, 3'd3, "R7 move");
    step(0, 0, 0, 0, 0, 3'd0, "R7 move0");
    // R3: ack clears
    step(1, 0, 1, 32'd40, 0, 3'd0, "R3 clear");
    // R8: write count equal to compare
    step(0, 1, 0, 32'd40, 0, 3'd1, "R8 write-eq");
    step(0, 0, 0, 0, 0, 3'd1, "R8 no-tick");
    step(1, 0, 0, 0, 0, 3'd1, "R8 next-tick");
    // R10: compare write under hold keeps interrupt
    step(1, 0, 1, 32'd200, 1, 3'd1, "R10 hold-ack");
    step(0, 0, 0, 0, 0, 3'd1, "R10 after");
    step(0, 0, 1, 32'd200, 0, 3'd1, "R3 clear2");
    // R9: hold freezes count and blocks match
    step(0, 1, 0, 32'd200, 0, 3'd4, "R9 load-eq");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 1, 3'd4, "R9 frozen");
    step(1, 0, 0, 0, 0, 3'd4, "R9 release");
    step(0, 0, 1, 32'd0, 0, 3'd4, "R3 clear3");
    // R11: wrap, compare 0
    step(0, 1, 0, 32'hFFFF_FFFE, 0, 3'd5, "R11 load");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 3'd5, "R11 wrap");
    step(0, 0, 0, 0, 0, 3'd5, "R11 end");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule